// File: doc/BRIEF.md
# Boost Regulator Start-Up and Fault Sequencer

This block is the digital state machine that brings a synchronous boost regulator up from off, keeps it running, and recovers it after trouble. The analog comparators, the pulse modulator and the slow timing oscillator sit outside it. Their results arrive as level flags, and the oscillator arrives as a one-cycle `tick` pulse on the system clock. Every timeout in the sequencer is a count of these ticks.

A start has four phases. The output is first charged through a linear current source at a low level. If that takes too long, the source switches to a higher level, and a second timeout then ends in a fault. Once the output is within a volt of the input, switching starts with the peak current limit at half scale. The limit ramps to full scale, and the output must reach 90% of its setpoint in a further window. On regulation the block enters normal boosting. There it watches for a sustained current limit and for output collapse.

A fault stops all switching, opens the input-to-output path, and retries after a long wait. Over-temperature parks the block until it cools, then resumes through soft-start. A missing protection diode latches the block off until the enable is cycled or both supply-lockout flags drop.

Top module: `boost_seq`

## Requirements
- R1: While `enable` is low, the next state is off (code 0) with `disconnect`=1, `sw_en`=0, `rect_en`=0, `src_sel`=0 and `ilim_scale`=0.
- R2: From off, with `enable` high, `vin_ok` high, no over-temperature and no diode latch, the block enters precharge stage 1 (code 1) on the next clock, with `src_sel`=1 (low current) and `disconnect`=0.
- R3: On the 16th tick in precharge stage 1, the block moves to precharge stage 2 (code 2) with `src_sel`=2 (high current).
- R4: On the 64th tick in precharge stage 2 without `near_vin`, the block enters fault (code 5).
- R5: `near_vin` high in either precharge stage moves the block to soft-start (code 3) on the next clock.
- R6: In soft-start, `ilim_scale` is 0 (half scale) at entry and rises by one every 4 ticks. It holds at 8 (full scale) from the 32nd tick onward. In normal boosting it is 8.
- R7: In soft-start, `in_reg` moves the block to boost (code 4). If `at_90` has not been seen by the 128th tick, the block enters fault.
- R8: In fault, `disconnect`=1 and both switch enables are 0. On the 480th tick the block restarts in precharge stage 1.
- R9: `sw_en` is 1 only in soft-start or boost, and is 0 in any cycle with `fb_high` set.
- R10: In boost, 32 consecutive ticks with `ilim_hit` cause a fault. A tick without `ilim_hit` restarts that count.
- R11: In boost, `near_vin` low drops `rect_en` in the same cycle and enters fault on the next clock.
- R12: `over_temp` in any running state moves the block to the cooling state (code 6), with all switches off and `disconnect`=1. Clearing `over_temp` moves it to soft-start.
- R13: `diode_miss` latches the block into off. The latch clears on a falling `enable`, or when `vout_ok` and `vin_ok` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Regulator enable |
| vin_ok | input | 1 | Input above its lockout threshold |
| vout_ok | input | 1 | Output above its lockout threshold |
| tick | input | 1 | One-cycle timing pulse from the slow oscillator |
| near_vin | input | 1 | Output within 1 V of the input |
| at_90 | input | 1 | Output at or above 90% of setpoint |
| in_reg | input | 1 | Output in regulation |
| fb_high | input | 1 | Feedback above reference |
| ilim_hit | input | 1 | Peak current limit reached this cycle |
| over_temp | input | 1 | Die over temperature |
| diode_miss | input | 1 | Output protection diode missing |
| state_code | output | 3 | 0 off, 1 precharge-1, 2 precharge-2, 3 soft-start, 4 boost, 5 fault, 6 cooling |
| src_sel | output | 2 | Linear source: 0 off, 1 low, 2 high |
| ilim_scale | output | 4 | Current-limit step: 0 = half scale, 8 = full scale |
| sw_en | output | 1 | Boost switch enable |
| rect_en | output | 1 | Synchronous rectifier enable |
| disconnect | output | 1 | Input-to-output path held open |

## Verification
The properties assume that `tick` is a single-cycle pulse and that the comparator flags are levels that change only between clock edges. They also assume that no start is attempted in the same cycle as a diode or temperature event. The bench drives every input on the falling clock edge and separates ticks by an idle cycle. It changes one flag at a time, so each transition is caused by exactly one input. Timeout boundaries are reached by counting ticks from a known state entry, and the output is checked one tick before and at the limit.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;
   typedef enum logic [2:0] {
      ST_OFF  = 3'd0,
      ST_PRE1 = 3'd1,
      ST_PRE2 = 3'd2,
      ST_RAMP = 3'd3,
      ST_RUN  = 3'd4,
      ST_TRIP = 3'd5,
      ST_HOT  = 3'd6
   } seq_state_e;

   localparam logic [1:0] SRC_NONE = 2'd0;
   localparam logic [1:0] SRC_LOW  = 2'd1;
   localparam logic [1:0] SRC_HIGH = 2'd2;
endpackage

// File: rtl/boost_seq_timer.sv
module boost_seq_timer #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [CW-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count <= '0;
      else if (clr)                    count <= '0;
      else if (tick && (count != '1))  count <= count + 1'b1;
   end
endmodule

// File: rtl/boost_seq_ilim_watch.sv
module boost_seq_ilim_watch #(
   parameter int LIMIT = 32,
   localparam int LW = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic hit,
   output logic trip
);
   logic [LW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_len <= '0;
      else if (clr)    run_len <= '0;
      else if (tick) begin
         if (!hit)                         run_len <= '0;
         else if (run_len != LW'(LIMIT))   run_len <= run_len + 1'b1;
      end
   end

   assign trip = tick && hit && (run_len == LW'(LIMIT - 1));
endmodule

// File: rtl/boost_seq_diode_latch.sv
module boost_seq_diode_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic diode_miss,
   input  logic vout_ok,
   input  logic vin_ok,
   output logic latched
);
   logic en_q;
   logic en_fell;

   assign en_fell = en_q && !enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         latched <= 1'b0;
      end else begin
         en_q <= enable;
         if (diode_miss)                         latched <= 1'b1;
         else if (en_fell || (!vout_ok && !vin_ok)) latched <= 1'b0;
      end
   end
endmodule

// File: rtl/boost_seq.sv
module boost_seq
   import boost_seq_pkg::*;
#(
   parameter int PRE1_TICKS  = 16,
   parameter int PRE2_TICKS  = 64,
   parameter int RAMP_TICKS  = 32,
   parameter int RAMP_STEPS  = 8,
   parameter int REACH_TICKS = 96,
   parameter int ILIM_TICKS  = 32,
   parameter int RETRY_TICKS = 480,
   localparam int SCALE_W = $clog2(RAMP_STEPS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               vin_ok,
   input  logic               vout_ok,
   input  logic               tick,
   input  logic               near_vin,
   input  logic               at_90,
   input  logic               in_reg,
   input  logic               fb_high,
   input  logic               ilim_hit,
   input  logic               over_temp,
   input  logic               diode_miss,
   output logic [2:0]         state_code,
   output logic [1:0]         src_sel,
   output logic [SCALE_W-1:0] ilim_scale,
   output logic               sw_en,
   output logic               rect_en,
   output logic               disconnect
);
   localparam int SS_LIMIT   = RAMP_TICKS + REACH_TICKS;
   localparam int MAX_A      = (PRE1_TICKS > PRE2_TICKS) ? PRE1_TICKS : PRE2_TICKS;
   localparam int MAX_B      = (SS_LIMIT > RETRY_TICKS) ? SS_LIMIT : RETRY_TICKS;
   localparam int MAX_T      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CW         = $clog2(MAX_T + 1);
   localparam int STEP_TICKS = RAMP_TICKS / RAMP_STEPS;

   if (RAMP_STEPS < 1 || RAMP_TICKS % RAMP_STEPS != 0) begin : g_bad_ramp
      $error("RAMP_TICKS must be a positive multiple of RAMP_STEPS");
   end
   if (PRE1_TICKS < 1 || PRE2_TICKS < 1 || RETRY_TICKS < 1 || ILIM_TICKS < 1) begin : g_bad_tmo
      $error("every timeout must be at least one tick");
   end

   seq_state_e st_q, st_d;
   logic [CW-1:0] cnt;
   logic          entering;
   logic          latched;
   logic          ilim_trip;
   logic          seen90_q;
   logic          pre1_done, pre2_done, ramp_fail, retry_done;
   logic [CW-1:0] step_idx;

   assign entering = (st_d != st_q);

   boost_seq_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(entering), .tick(tick), .count(cnt)
   );

   boost_seq_ilim_watch #(.LIMIT(ILIM_TICKS)) u_ilim (
      .clk(clk), .rst_n(rst_n), .clr(entering || (st_q != ST_RUN)),
      .tick(tick), .hit(ilim_hit), .trip(ilim_trip)
   );

   boost_seq_diode_latch u_latch (
      .clk(clk), .rst_n(rst_n), .enable(enable), .diode_miss(diode_miss),
      .vout_ok(vout_ok), .vin_ok(vin_ok), .latched(latched)
   );

   assign pre1_done  = tick && (cnt == CW'(PRE1_TICKS - 1));
   assign pre2_done  = tick && (cnt == CW'(PRE2_TICKS - 1));
   assign retry_done = tick && (cnt == CW'(RETRY_TICKS - 1));
   assign ramp_fail  = tick && (cnt == CW'(SS_LIMIT - 1)) && !seen90_q && !at_90;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_OFF;
         seen90_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (entering)                       seen90_q <= 1'b0;
         else if (st_q == ST_RAMP && at_90)  seen90_q <= 1'b1;
      end
   end

   always_comb begin
      st_d = st_q;
      if (!enable || latched || diode_miss) begin
         st_d = ST_OFF;
      end else if (over_temp && st_q != ST_OFF) begin
         st_d = ST_HOT;
      end else begin
         case (st_q)
            ST_OFF:  if (vin_ok && !over_temp) st_d = ST_PRE1;
            ST_PRE1: if (near_vin)             st_d = ST_RAMP;
                     else if (pre1_done)       st_d = ST_PRE2;
            ST_PRE2: if (near_vin)             st_d = ST_RAMP;
                     else if (pre2_done)       st_d = ST_TRIP;
            ST_RAMP: if (in_reg)               st_d = ST_RUN;
                     else if (ramp_fail)       st_d = ST_TRIP;
            ST_RUN:  if (!near_vin || ilim_trip) st_d = ST_TRIP;
            ST_TRIP: if (retry_done)           st_d = ST_PRE1;
            ST_HOT:                            st_d = ST_RAMP;
            default:                           st_d = ST_OFF;
         endcase
      end
   end

   if ((STEP_TICKS & (STEP_TICKS - 1)) == 0) begin : g_step_shift
      localparam int STEP_SH = $clog2(STEP_TICKS);
      assign step_idx = cnt >> STEP_SH;
   end else begin : g_step_div
      assign step_idx = cnt / CW'(STEP_TICKS);
   end

   logic switching;
   assign switching = (st_q == ST_RAMP) || (st_q == ST_RUN);

   always_comb begin
      ilim_scale = '0;
      if (st_q == ST_RUN)
         ilim_scale = SCALE_W'(RAMP_STEPS);
      else if (st_q == ST_RAMP)
         ilim_scale = (cnt >= CW'(RAMP_TICKS)) ? SCALE_W'(RAMP_STEPS) : SCALE_W'(step_idx);
   end

   always_comb begin
      case (st_q)
         ST_PRE1: src_sel = SRC_LOW;
         ST_PRE2: src_sel = SRC_HIGH;
         default: src_sel = SRC_NONE;
      endcase
   end

   assign state_code = st_q;
   assign sw_en      = switching && !fb_high;
   assign rect_en    = switching && near_vin;
   assign disconnect = (st_q == ST_OFF) || (st_q == ST_TRIP) || (st_q == ST_HOT);
endmodule

// File: rtl/boost_seq_chk.sv
module boost_seq_chk #(
   parameter int SCALE_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               enable,
   input logic               near_vin,
   input logic               fb_high,
   input logic               over_temp,
   input logic               diode_miss,
   input logic [2:0]         state_code,
   input logic [1:0]         src_sel,
   input logic [SCALE_W-1:0] ilim_scale,
   input logic               sw_en,
   input logic               rect_en,
   input logic               disconnect
);
   a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (state_code == 3'd0) && disconnect && !sw_en && !rect_en);

   a_r3_high_source_stage2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd2) |-> (src_sel == 2'd2));

   a_r6_scale_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd3) && ($past(state_code) == 3'd3) |-> (ilim_scale >= $past(ilim_scale)));

   a_r8_fault_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd5) |-> disconnect && !sw_en && !rect_en);

   a_r9_fb_blocks_switch: assert property (@(posedge clk) disable iff (!rst_n)
      fb_high |-> !sw_en);

   a_r11_collapse_trips: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd4) && !near_vin && enable && !over_temp && !diode_miss
      |-> !rect_en ##1 (state_code == 3'd5));

   a_r12_hot_entry: assert property (@(posedge clk) disable iff (!rst_n)
      over_temp && enable && !diode_miss && (state_code != 3'd0) |=> (state_code == 3'd6));

   a_r13_diode_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
      diode_miss |=> (state_code == 3'd0));

   a_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      state_code <= 3'd6);
endmodule

bind boost_seq boost_seq_chk #(.SCALE_W(SCALE_W)) u_chk (.*);

// File: tb/boost_seq_test.sv
module boost_seq_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 0, vin_ok = 0, vout_ok = 0, tick = 0, near_vin = 0, at_90 = 0;
   logic in_reg = 0, fb_high = 0, ilim_hit = 0, over_temp = 0, diode_miss = 0;
   logic [2:0] state_code;
   logic [1:0] src_sel;
   logic [3:0] ilim_scale;
   logic sw_en, rect_en, disconnect;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   boost_seq uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .vin_ok(vin_ok), .vout_ok(vout_ok),
      .tick(tick), .near_vin(near_vin), .at_90(at_90), .in_reg(in_reg),
      .fb_high(fb_high), .ilim_hit(ilim_hit), .over_temp(over_temp),
      .diode_miss(diode_miss), .state_code(state_code), .src_sel(src_sel),
      .ilim_scale(ilim_scale), .sw_en(sw_en), .rect_en(rect_en), .disconnect(disconnect)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic go_run();
      enable = 0; clocks(1);
      enable = 1; near_vin = 0; in_reg = 0; at_90 = 0; clocks(1);
      near_vin = 1; clocks(1);
      at_90 = 1; in_reg = 1; clocks(1);
   endtask

   task automatic t_reset();
      chk("R1 reset state", state_code, 0);
      chk("R1 reset disconnect", disconnect, 1);
      chk("R1 reset switches", {sw_en, rect_en, src_sel}, 0);
   endtask

   task automatic t_precharge_timeouts();
      vin_ok = 1; vout_ok = 1; enable = 1; clocks(1);
      chk("R2 enter stage1", state_code, 1);
      chk("R2 low source", src_sel, 1);
      chk("R2 path closed", disconnect, 0);
      ticks(15);
      chk("R3 stage1 before limit", state_code, 1);
      ticks(1);
      chk("R3 stage2 at limit", state_code, 2);
      chk("R3 high source", src_sel, 2);
      ticks(63);
      chk("R4 stage2 before limit", state_code, 2);
      ticks(1);
      chk("R4 fault at limit", state_code, 5);
      chk("R8 fault disconnect", disconnect, 1);
      chk("R8 fault switches off", {sw_en, rect_en}, 0);
      ticks(479);
      chk("R8 fault before retry", state_code, 5);
      ticks(1);
      chk("R8 retry to stage1", state_code, 1);
   endtask

   task automatic t_softstart();
      near_vin = 1; clocks(1);
      chk("R5 near moves to soft-start", state_code, 3);
      chk("R6 half scale at entry", ilim_scale, 0);
      chk("R9 switch on in soft-start", sw_en, 1);
      ticks(4);
      chk("R6 one step after 4 ticks", ilim_scale, 1);
      ticks(28);
      chk("R6 full scale after 32 ticks", ilim_scale, 8);
      fb_high = 1; #1;
      chk("R9 feedback high blocks switch", sw_en, 0);
      @(negedge clk) fb_high = 0; #1;
      chk("R9 switch back on", sw_en, 1);
      ticks(95);
      chk("R7 soft-start before limit", state_code, 3);
      ticks(1);
      chk("R7 fault without 90 percent", state_code, 5);
   endtask

   task automatic t_run_entry();
      enable = 0; clocks(1);
      chk("R1 disable from fault", state_code, 0);
      chk("R1 disable disconnects", disconnect, 1);
      go_run();
      chk("R7 regulation enters boost", state_code, 4);
      chk("R6 full scale in boost", ilim_scale, 8);
      chk("R11 rectifier on in boost", rect_en, 1);
   endtask

   task automatic t_ilim();
      ilim_hit = 1; ticks(31);
      ilim_hit = 0; ticks(1);
      ilim_hit = 1; ticks(31);
      chk("R10 broken run does not trip", state_code, 4);
      ticks(1);
      chk("R10 32 consecutive hits trip", state_code, 5);
      ilim_hit = 0;
   endtask

   task automatic t_collapse();
      go_run();
      near_vin = 0; #1;
      chk("R11 rectifier off same cycle", rect_en, 0);
      chk("R11 still boost before edge", state_code, 4);
      clocks(1);
      chk("R11 collapse trips", state_code, 5);
      near_vin = 1;
   endtask

   task automatic t_hot();
      go_run();
      over_temp = 1; clocks(1);
      chk("R12 cooling state", state_code, 6);
      chk("R12 cooling isolated", {disconnect, sw_en, rect_en}, 3'b100);
      in_reg = 0; over_temp = 0; clocks(1);
      chk("R12 restart via soft-start", state_code, 3);
   endtask

   task automatic t_diode();
      diode_miss = 1; clocks(1);
      chk("R13 diode forces off", state_code, 0);
      diode_miss = 0; clocks(3);
      chk("R13 latch holds off", state_code, 0);
      enable = 0; clocks(1);
      enable = 1; clocks(1);
      chk("R13 enable toggle restarts", state_code, 1);
      diode_miss = 1; clocks(1);
      diode_miss = 0; vin_ok = 0; vout_ok = 0; clocks(1);
      vin_ok = 1; clocks(1);
      chk("R13 lockout clears latch", state_code, 1);
      enable = 0; clocks(1);
      chk("R1 final disable", state_code, 0);
   endtask

   initial begin
      clocks(3);
      rst_n = 1'b1;
      clocks(1);
      t_reset();
      t_precharge_timeouts();
      t_softstart();
      t_run_entry();
      t_ilim();
      t_collapse();
      t_hot();
      t_diode();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule